// File: doc/BRIEF.md
# Level Interrupt Gateway with Claim Tracking

This block sits between a set of level-sensitive interrupt lines and the priority arbiter of a platform-level interrupt controller. For every source it records whether an interrupt is waiting to be taken (pending) and whether a handler currently owns it (claimed). A handler takes a source by presenting a one-cycle claim strobe with the source number. It gives the source back by presenting a one-cycle completion strobe with the same number.

While a source is owned, its line cannot raise pending again. If the line is high during that window, the gateway notes the fact in a third, internal bit. When the handler completes, that bit turns into a fresh pending request, so a level that is still asserted is not lost. If the line falls before completion, the note is dropped. Source number 0 is reserved and means "no interrupt". The state is held in 32-bit slices: source N lives in slice N/32 at bit N%32.

Inputs are sampled on the rising clock edge and must already be synchronous to the clock. Both output vectors come straight from registers and change one cycle after the input or strobe that causes the change.

Top module: `irq_claim_gateway`

## Requirements
- R1: A synchronous active-high reset clears every pending, claimed and internal deferred bit. Reset overrides any active input line.
- R2: A source whose line is high at a clock edge, and which is neither claimed nor being claimed at that edge, shows its pending bit set after the edge. The pending bit stays set after the line falls, until the source is claimed.
- R3: A claim strobe for source N clears pending bit N and sets claimed bit N at the next edge.
- R4: While claimed bit N is set, a high level on line N never sets pending bit N.
- R5: A completion for a claimed source N clears claimed bit N at the next edge. If line N was high at the edges since the claim took effect, and is still high at the edge before completion, pending bit N is set at the same edge.
- R6: If line N rises and then falls again while N is claimed, completing N leaves pending bit N clear.
- R7: A completion naming a source that is not claimed changes neither the pending nor the claimed vector.
- R8: Source number 0 is reserved. Line 0 is ignored, strobes carrying number 0 are ignored, and output bit 0 of both vectors is always 0.
- R9: No source is ever pending and claimed at the same time.
- R10: Strobes for one source leave every other source unchanged. A claim and a completion for different sources in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_SRC | Level-sensitive interrupt lines, bit N for source N |
| claim_vld_i | input | 1 | Claim strobe, one cycle per claim |
| claim_id_i | input | ID_W | Source number being claimed |
| cmpl_vld_i | input | 1 | Completion strobe, one cycle per completion |
| cmpl_id_i | input | ID_W | Source number being completed |
| pending_o | output | NUM_SRC | Registered pending vector for the arbiter |
| claimed_o | output | NUM_SRC | Registered claimed vector |

## Verification
The gateway is driven with four kinds of line pattern. A short pulse on an idle source shows that pending is sticky. A level held high across a whole claim window shows that the deferred note is turned into a new request on completion. A pulse that rises and falls inside the claim window shows that the note is dropped on the falling edge. Two sources active together show that strobes for one source leave the other untouched. Stray completions for unclaimed sources and strobes naming the reserved source 0 are also applied, and the bench checks that both vectors stay exactly as they were.

// File: rtl/igw_pkg.sv
package igw_pkg;
  // Width of one storage slice; source N lives in slice N/32, bit N%32.
  localparam int WORD_W = 32;

  function automatic int slice_count(input int n_src);
    return (n_src + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int slice_width(input int n_src, input int slice);
    int rest;
    rest = n_src - slice * WORD_W;
    return (rest > WORD_W) ? WORD_W : rest;
  endfunction
endpackage

// File: rtl/igw_id_decode.sv
module igw_id_decode #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input  logic               vld_i,
  input  logic [ID_W-1:0]    id_i,
  output logic [NUM_SRC-1:0] hot_o
);
  // Bit 0 is the reserved "no interrupt" number and never decodes.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    if (i == 0) begin : g_rsvd
      assign hot_o[i] = 1'b0;
    end else begin : g_src
      assign hot_o[i] = vld_i && (id_i == ID_W'(i));
    end
  end
endmodule

// File: rtl/igw_slice.sv
module igw_slice #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] claim_hot_i,
  input  logic [WIDTH-1:0] cmpl_hot_i,
  output logic [WIDTH-1:0] pending_q,
  output logic [WIDTH-1:0] claimed_q
);
  logic [WIDTH-1:0] deferred_q;
  logic [WIDTH-1:0] done;
  logic [WIDTH-1:0] pending_d;
  logic [WIDTH-1:0] claimed_d;
  logic [WIDTH-1:0] deferred_d;

  always_comb begin
    // A completion only counts for a source that is currently claimed.
    done       = cmpl_hot_i & claimed_q;
    claimed_d  = (claimed_q & ~done) | claim_hot_i;
    pending_d  = (pending_q | (line_i & ~claimed_q) | (done & deferred_q))
                 & ~claim_hot_i;
    // The note exists only while claimed and dies when the line drops.
    deferred_d = line_i & claimed_q & ~done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q  <= '0;
      claimed_q  <= '0;
      deferred_q <= '0;
    end else begin
      pending_q  <= pending_d;
      claimed_q  <= claimed_d;
      deferred_q <= deferred_d;
    end
  end
endmodule

// File: rtl/irq_claim_gateway.sv
module irq_claim_gateway #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               claim_vld_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               cmpl_vld_i,
  input  logic [ID_W-1:0]    cmpl_id_i,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] claimed_o
);
  import igw_pkg::*;

  localparam int N_SLICE = slice_count(NUM_SRC);

  logic [NUM_SRC-1:0] line_m;
  logic [NUM_SRC-1:0] claim_hot;
  logic [NUM_SRC-1:0] cmpl_hot;

  // Line 0 belongs to the reserved number and is masked off.
  assign line_m = irq_i & ~NUM_SRC'(1);

  igw_id_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_claim_dec (
    .vld_i (claim_vld_i),
    .id_i  (claim_id_i),
    .hot_o (claim_hot)
  );

  igw_id_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_cmpl_dec (
    .vld_i (cmpl_vld_i),
    .id_i  (cmpl_id_i),
    .hot_o (cmpl_hot)
  );

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    localparam int LO = s * WORD_W;
    localparam int WW = slice_width(NUM_SRC, s);
    igw_slice #(.WIDTH(WW)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .line_i      (line_m[LO +: WW]),
      .claim_hot_i (claim_hot[LO +: WW]),
      .cmpl_hot_i  (cmpl_hot[LO +: WW]),
      .pending_q   (pending_o[LO +: WW]),
      .claimed_q   (claimed_o[LO +: WW])
    );
  end
endmodule

// File: rtl/igw_checker.sv
module igw_checker #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               claim_vld_i,
  input logic [ID_W-1:0]    claim_id_i,
  input logic               cmpl_vld_i,
  input logic [ID_W-1:0]    cmpl_id_i,
  input logic [NUM_SRC-1:0] pending_o,
  input logic [NUM_SRC-1:0] claimed_o
);
  // R1: the cycle after reset both vectors are empty.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pending_o == '0) && (claimed_o == '0));

  // R9: pending and claimed are exclusive per source.
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    (pending_o & claimed_o) == '0);

  // R8: reserved bit never shows up.
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !pending_o[0] && !claimed_o[0]);

  // R3: a valid claim leaves the source claimed and not pending.
  p_claim_takes_r3: assert property (@(posedge clk) disable iff (rst)
    (claim_vld_i && claim_id_i != '0 && int'(claim_id_i) < NUM_SRC)
    |=> claimed_o[$past(claim_id_i)] && !pending_o[$past(claim_id_i)]);

  // R7: completing an unclaimed source leaves ownership untouched.
  p_stray_cmpl_r7: assert property (@(posedge clk) disable iff (rst)
    (cmpl_vld_i && !claim_vld_i && int'(cmpl_id_i) < NUM_SRC
     && !claimed_o[cmpl_id_i])
    |=> $stable(claimed_o));

  // R2 / R4: per-source line behaviour.
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    p_line_sets_r2: assert property (@(posedge clk) disable iff (rst)
      (irq_i[i] && !claimed_o[i] && !(claim_vld_i && claim_id_i == ID_W'(i)))
      |=> pending_o[i]);
    p_claimed_blocks_r4: assert property (@(posedge clk) disable iff (rst)
      (claimed_o[i] && !(cmpl_vld_i && cmpl_id_i == ID_W'(i)))
      |=> !pending_o[i]);
  end
endmodule

bind irq_claim_gateway igw_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_igw_checker (
  .clk         (clk),
  .rst         (rst),
  .irq_i       (irq_i),
  .claim_vld_i (claim_vld_i),
  .claim_id_i  (claim_id_i),
  .cmpl_vld_i  (cmpl_vld_i),
  .cmpl_id_i   (cmpl_id_i),
  .pending_o   (pending_o),
  .claimed_o   (claimed_o)
);

// File: tb/test_irq_claim_gateway.sv
module test_irq_claim_gateway;
  localparam int NUM_SRC = 32;
  localparam int ID_W    = 5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] irq_i = '0;
  logic               claim_vld_i = 1'b0;
  logic [ID_W-1:0]    claim_id_i = '0;
  logic               cmpl_vld_i = 1'b0;
  logic [ID_W-1:0]    cmpl_id_i = '0;
  logic [NUM_SRC-1:0] pending_o;
  logic [NUM_SRC-1:0] claimed_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_claim_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) i_irq_claim_gateway (
    .clk, .rst, .irq_i, .claim_vld_i, .claim_id_i,
    .cmpl_vld_i, .cmpl_id_i, .pending_o, .claimed_o
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [NUM_SRC-1:0] act,
                       input logic [NUM_SRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic claim(input int id);
    claim_vld_i = 1'b1; claim_id_i = ID_W'(id);
    tick();
    claim_vld_i = 1'b0;
  endtask

  task automatic complete(input int id);
    cmpl_vld_i = 1'b1; cmpl_id_i = ID_W'(id);
    tick();
    cmpl_vld_i = 1'b0;
  endtask

  function automatic logic [NUM_SRC-1:0] b(input int n);
    return NUM_SRC'(1) << n;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    irq_i = b(5);
    tick(); tick();
    check("R1 pending in reset", pending_o, '0);
    check("R1 claimed in reset", claimed_o, '0);
    irq_i = '0; rst = 1'b0;
    tick();
    check("R1 pending after reset", pending_o, '0);
  endtask

  task automatic t_sticky();
    irq_i = b(3); tick();
    check("R2 pending on level", pending_o, b(3));
    irq_i = '0; tick(); tick();
    check("R2 pending sticky", pending_o, b(3));
    claim(3);
    check("R3 pending cleared", pending_o, '0);
    check("R3 claimed set", claimed_o, b(3));
    complete(3);
    check("R5 claimed released", claimed_o, '0);
    check("R5 no rearm when low", pending_o, '0);
  endtask

  task automatic t_held_level();
    irq_i = b(5); tick();
    claim(5);
    tick(); tick(); tick();
    check("R4 no pending while claimed", pending_o, '0);
    check("R4 still claimed", claimed_o, b(5));
    complete(5);
    check("R5 claimed cleared", claimed_o, '0);
    check("R5 rearmed pending", pending_o, b(5));
    irq_i = '0;
    claim(5); complete(5);
    check("R5 clean after rearm", pending_o | claimed_o, '0);
  endtask

  task automatic t_pulse_in_window();
    irq_i = b(7); tick();
    claim(7);
    tick(); tick();
    irq_i = '0; tick();
    complete(7);
    check("R6 dropped pulse no pending", pending_o, '0);
    check("R6 claimed cleared", claimed_o, '0);
  endtask

  task automatic t_stray_complete();
    irq_i = b(9) | b(10); tick();
    irq_i = '0;
    claim(9);
    complete(10);
    check("R7 pending unchanged", pending_o, b(10));
    check("R7 claimed unchanged", claimed_o, b(9));
    complete(11);
    check("R7 absent source pending", pending_o, b(10));
    check("R7 absent source claimed", claimed_o, b(9));
    complete(9); claim(10); complete(10);
    check("R7 cleanup", pending_o | claimed_o, '0);
  endtask

  task automatic t_reserved();
    irq_i = b(0); tick(); tick();
    check("R8 line 0 ignored", pending_o, '0);
    irq_i = '0;
    claim(0);
    check("R8 claim 0 ignored", claimed_o, '0);
    irq_i = b(4); tick(); irq_i = '0;
    complete(0);
    check("R8 complete 0 pending", pending_o, b(4));
    claim(4); complete(4);
  endtask

  task automatic t_independent();
    irq_i = b(12) | b(20); tick();
    irq_i = '0;
    claim(12);
    check("R10 other stays pending", pending_o, b(20));
    check("R10 only one claimed", claimed_o, b(12));
    claim_vld_i = 1'b1; claim_id_i = ID_W'(20);
    cmpl_vld_i  = 1'b1; cmpl_id_i  = ID_W'(12);
    tick();
    claim_vld_i = 1'b0; cmpl_vld_i = 1'b0;
    check("R10 swap claimed", claimed_o, b(20));
    check("R10 swap pending", pending_o, '0);
    irq_i = b(31); tick(); irq_i = '0;
    check("R2 top source pending", pending_o, b(31));
    complete(20); claim(31); complete(31);
    check("R10 all clear", pending_o | claimed_o, '0);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_held_level();
    t_pulse_in_window();
    t_stray_complete();
    t_reserved();
    t_independent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule